// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block decides whether a conditional branch is taken. A 5-bit branch-options code selects the parts of the test. It can decrement the count register and then require the new value to be zero or nonzero. It can require one condition-register bit to be set or clear. It can attach a static prediction hint. A code can combine these parts, or it can be the single "always taken" code. Codes outside the defined set are reserved and are reported as illegal.

The unit receives the condition register, the current count register, a flag for 32-bit mode and a flag that marks the branch-to-count-register form. All results are registered, so they appear one clock after the inputs are presented. The results are: the taken decision, the next count value with its write enable, an illegal-form flag and a two-bit hint. Target address generation, fetch and dynamic prediction belong to other blocks.

Top module: `branch_cond_unit`

## Requirements
- R1: The legal codes are 0, 2, 4, 6, 7, 8, 10, 12, 14, 15, 16, 18, 20, 24, 25, 26 and 27. Any other value of `bo_i` sets `illegal_o`.
- R2: A legal code with bit value 4 clear is a decrementing code. It sets `ctr_we_o` and drives `ctr_next_o` to `ctr_i - 1` (modulo 2^64), whether the branch is taken or not. Every other code clears `ctr_we_o` and passes `ctr_i` through unchanged on `ctr_next_o`.
- R3: For a decrementing code, bit value 2 of the code picks the counter test. When it is set, the decremented count must be zero. When it is clear, the decremented count must be nonzero.
- R4: When `mode32_i` is 1, the zero or nonzero test looks only at bits 31:0 of the decremented count. When it is 0, the test looks at all 64 bits.
- R5: A code with bit value 16 clear tests condition bit `cr_i[31 - bi_i]`. Bit 0 of the condition register is its most significant bit, and the bit for field f and offset k (lt=0, gt=1, eq=2, so=3) has index 4*f+k. The bit must be 1 when bit value 8 of the code is set, and 0 when it is clear.
- R6: Code 20 is always taken. A legal code is taken exactly when all of its selected tests pass.
- R7: `hint_o` is 2'b10 (predict not taken) for codes 6, 14, 24 and 26. It is 2'b11 (predict taken) for codes 7, 15, 25 and 27. It is 2'b00 (no hint) for all other codes.
- R8: A decrementing code presented together with `ctr_form_i` = 1 sets `illegal_o`.
- R9: When `illegal_o` is set, `taken_o` and `ctr_we_o` are 0, `hint_o` is 2'b00, and `ctr_next_o` equals `ctr_i`.
- R10: The outputs are registered with exactly one cycle of latency. While `rst_i` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bo_i | input | 5 | Branch-options code |
| bi_i | input | 5 | Condition-bit index |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 64 | Current count register |
| mode32_i | input | 1 | 1 selects 32-bit counter test |
| ctr_form_i | input | 1 | Branch-to-count-register form |
| taken_o | output | 1 | Branch taken |
| ctr_next_o | output | 64 | Next count value |
| ctr_we_o | output | 1 | Count register write enable |
| illegal_o | output | 1 | Reserved code or illegal form |
| hint_o | output | 2 | Static hint: 00 none, 10 not taken, 11 taken |

## Verification
The bench sweeps every code with both forms, both modes and counts chosen to sit on the zero boundary. A count of 1 shows whether the decrement happens before the test. With the wrong order, the zero and nonzero codes would swap results. The count 0x1_0000_0001 exposes a design that ignores the mode: in 32-bit mode it would report nonzero and take the wrong path. The bench also uses a 0 that wraps to all ones, and checks each condition index against both a pattern and its inverse. A reversed bit order or a swapped polarity would then miss half the branches. Reserved codes and decrementing codes in the count-register form must suppress the write. A design that still decremented would corrupt the count for an instruction that must never execute.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        HINT_NONE      = 2'b00,
        HINT_NOT_TAKEN = 2'b10,
        HINT_TAKEN     = 2'b11
    } hint_e;

    // Decoded fields of a branch-options code
    typedef struct packed {
        logic  legal;     // code is in the defined set
        logic  dec;       // decrement the counter
        logic  want_zero; // counter test sense
        logic  use_cr;    // test a condition bit
        logic  cr_true;   // required condition-bit value
        hint_e hint;
    } bo_fields_t;

    // Decision produced by the combinational core
    typedef struct packed {
        logic  taken;
        logic  ctr_we;
        logic  illegal;
        hint_e hint;
    } decision_t;

    function automatic logic code_is_legal(input logic [CODE_W-1:0] code);
        logic ok;
        case (code)
            5'd0, 5'd2, 5'd4, 5'd6, 5'd7, 5'd8, 5'd10, 5'd12,
            5'd14, 5'd15, 5'd16, 5'd18, 5'd20,
            5'd24, 5'd25, 5'd26, 5'd27: ok = 1'b1;
            default:                    ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic bo_fields_t split_code(input logic [CODE_W-1:0] code);
        bo_fields_t f;
        logic       has_hint;
        f.legal     = code_is_legal(code);
        f.dec       = ~code[2];
        f.want_zero = code[1];
        f.use_cr    = ~code[4];
        f.cr_true   = code[3];
        // hinted counter codes: 24..27, hinted bit codes: 6,7,14,15
        has_hint    = (f.dec && code[4] && code[3]) ||
                      (!f.dec && !code[4] && code[1]);
        if (!f.legal || !has_hint)
            f.hint = HINT_NONE;
        else if (code[0])
            f.hint = HINT_TAKEN;
        else
            f.hint = HINT_NOT_TAKEN;
        return f;
    endfunction

endpackage

// File: rtl/branch_cond_decode.sv
module branch_cond_decode
    import branch_cond_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              ctr_form_i,
    output bo_fields_t        fields_o,
    output logic              illegal_o
);
    bo_fields_t raw;

    always_comb begin
        raw       = split_code(code_i);
        illegal_o = !raw.legal || (ctr_form_i && raw.dec);
        fields_o  = raw;
        if (illegal_o) begin
            fields_o.dec  = 1'b0;
            fields_o.hint = HINT_NONE;
        end
    end
endmodule

// File: rtl/branch_cond_counter.sv
module branch_cond_counter #(
    parameter int CTR_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic [CTR_W-1:0] ctr_i,
    input  logic             mode_narrow_i,
    input  logic             dec_i,
    input  logic             want_zero_i,
    output logic [CTR_W-1:0] ctr_next_o,
    output logic             ctr_ok_o
);
    logic [CTR_W-1:0] minus_one;
    logic             wide_zero;
    logic             narrow_zero;
    logic             is_zero;

    always_comb begin
        minus_one   = ctr_i - {{(CTR_W-1){1'b0}}, 1'b1};
        wide_zero   = (minus_one == '0);
        narrow_zero = (minus_one[NARROW_W-1:0] == '0);
        is_zero     = mode_narrow_i ? narrow_zero : wide_zero;
        ctr_next_o  = dec_i ? minus_one : ctr_i;
        if (!dec_i)
            ctr_ok_o = 1'b1;
        else
            ctr_ok_o = want_zero_i ? is_zero : !is_zero;
    end
endmodule

// File: rtl/branch_cond_crbit.sv
module branch_cond_crbit #(
    parameter int CR_W = 32,
    localparam int IDX_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]  cr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             use_i,
    input  logic             want_set_i,
    output logic             cr_ok_o
);
    logic [CR_W-1:0] msb_first;
    logic            sel;

    // bit index 0 names the most significant bit
    for (genvar g = 0; g < CR_W; g++) begin : g_rev
        assign msb_first[g] = cr_i[CR_W-1-g];
    end

    always_comb begin
        sel     = msb_first[idx_i];
        cr_ok_o = !use_i || (sel == want_set_i);
    end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import branch_cond_pkg::*;
#(
    parameter int CTR_W    = 64,
    parameter int NARROW_W = 32,
    parameter int CR_W     = 32,
    localparam int IDX_W   = $clog2(CR_W)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [CODE_W-1:0]   bo_i,
    input  logic [IDX_W-1:0]    bi_i,
    input  logic [CR_W-1:0]     cr_i,
    input  logic [CTR_W-1:0]    ctr_i,
    input  logic                mode32_i,
    input  logic                ctr_form_i,
    output logic                taken_o,
    output logic [CTR_W-1:0]    ctr_next_o,
    output logic                ctr_we_o,
    output logic                illegal_o,
    output logic [1:0]          hint_o
);
    bo_fields_t       fields;
    logic             illegal_c;
    logic [CTR_W-1:0] ctr_next_c;
    logic             ctr_ok;
    logic             cr_ok;
    decision_t        dec_c;
    decision_t        dec_q;
    logic [CTR_W-1:0] ctr_next_q;

    branch_cond_decode i_decode (
        .code_i     (bo_i),
        .ctr_form_i (ctr_form_i),
        .fields_o   (fields),
        .illegal_o  (illegal_c)
    );

    branch_cond_counter #(
        .CTR_W    (CTR_W),
        .NARROW_W (NARROW_W)
    ) i_counter (
        .ctr_i         (ctr_i),
        .mode_narrow_i (mode32_i),
        .dec_i         (fields.dec),
        .want_zero_i   (fields.want_zero),
        .ctr_next_o    (ctr_next_c),
        .ctr_ok_o      (ctr_ok)
    );

    branch_cond_crbit #(
        .CR_W (CR_W)
    ) i_crbit (
        .cr_i       (cr_i),
        .idx_i      (bi_i),
        .use_i      (fields.use_cr),
        .want_set_i (fields.cr_true),
        .cr_ok_o    (cr_ok)
    );

    always_comb begin
        dec_c.illegal = illegal_c;
        dec_c.taken   = !illegal_c && ctr_ok && cr_ok;
        dec_c.ctr_we  = fields.dec;
        dec_c.hint    = fields.hint;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dec_q      <= '{taken: 1'b0, ctr_we: 1'b0, illegal: 1'b0, hint: HINT_NONE};
            ctr_next_q <= '0;
        end else begin
            dec_q      <= dec_c;
            ctr_next_q <= ctr_next_c;
        end
    end

    assign taken_o    = dec_q.taken;
    assign ctr_we_o   = dec_q.ctr_we;
    assign illegal_o  = dec_q.illegal;
    assign hint_o     = dec_q.hint;
    assign ctr_next_o = ctr_next_q;
endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk #(
    parameter int CTR_W = 64,
    parameter int CR_W  = 32,
    localparam int IDX_W = $clog2(CR_W)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [4:0]       bo_i,
    input logic [CTR_W-1:0] ctr_i,
    input logic             ctr_form_i,
    input logic             taken_o,
    input logic [CTR_W-1:0] ctr_next_o,
    input logic             ctr_we_o,
    input logic             illegal_o,
    input logic [1:0]       hint_o
);
    logic armed;
    always_ff @(posedge clk_i) begin
        if (rst_i) armed <= 1'b0;
        else       armed <= 1'b1;
    end

    // R9: an illegal form does nothing
    a_r9_illegal_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (!taken_o && !ctr_we_o && hint_o == 2'b00));

    // R7: hint encoding 01 never appears
    a_r7_hint_code: assert property (@(posedge clk_i) disable iff (rst_i)
        hint_o != 2'b01);

    // R2: the written count is one less than the count presented
    a_r2_decrement: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && ctr_we_o) |-> (ctr_next_o == $past(ctr_i) - 1));

    // R6: code 20 is always taken
    a_r6_always: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && $past(bo_i) == 5'd20) |-> taken_o);

    // R8: decrementing code on the count-register form
    a_r8_ctr_form: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && $past(ctr_form_i) && !$past(bo_i[2])) |-> illegal_o);

    // R10: reset clears outputs on the next edge
    a_r10_reset: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!taken_o && !ctr_we_o && !illegal_o && ctr_next_o == '0));
endmodule

bind branch_cond_unit branch_cond_unit_chk #(
    .CTR_W (CTR_W),
    .CR_W  (CR_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bo_i       (bo_i),
    .ctr_i      (ctr_i),
    .ctr_form_i (ctr_form_i),
    .taken_o    (taken_o),
    .ctr_next_o (ctr_next_o),
    .ctr_we_o   (ctr_we_o),
    .illegal_o  (illegal_o),
    .hint_o     (hint_o)
);

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [4:0]  bo_i = '0;
    logic [4:0]  bi_i = '0;
    logic [31:0] cr_i = '0;
    logic [63:0] ctr_i = '0;
    logic        mode32_i = 1'b0;
    logic        ctr_form_i = 1'b0;
    logic        taken_o;
    logic [63:0] ctr_next_o;
    logic        ctr_we_o;
    logic        illegal_o;
    logic [1:0]  hint_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk_i = ~clk_i;

    branch_cond_unit i_branch_cond_unit (
        .clk_i(clk_i), .rst_i(rst_i), .bo_i(bo_i), .bi_i(bi_i), .cr_i(cr_i),
        .ctr_i(ctr_i), .mode32_i(mode32_i), .ctr_form_i(ctr_form_i),
        .taken_o(taken_o), .ctr_next_o(ctr_next_o), .ctr_we_o(ctr_we_o),
        .illegal_o(illegal_o), .hint_o(hint_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (bo=%0d bi=%0d ctr=%0h m32=%0b form=%0b)",
                     req, act, exp, bo_i, bi_i, ctr_i, mode32_i, ctr_form_i);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic bit legal_set(input int c);
        int list [17] = '{0, 2, 4, 6, 7, 8, 10, 12, 14, 15, 16, 18, 20, 24, 25, 26, 27};
        foreach (list[i]) if (list[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [63:0] ctr_vals [5];
        ctr_vals = '{64'd1, 64'd2, 64'd0, 64'h1_0000_0001, 64'h0000_0003_0000_0000};

        // R10: reset state
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        chk(!taken_o && !ctr_we_o && !illegal_o && hint_o == 2'b00 && ctr_next_o == 0,
            "R10 reset", {taken_o, ctr_we_o, illegal_o, hint_o}, 0);
        rst_i = 1'b0;

        // R10: one-cycle latency, output held until the edge
        bo_i = 5'd20; ctr_i = 64'd9;
        @(posedge clk_i); #1;
        chk(taken_o == 1'b1, "R10 latency", taken_o, 1);
        @(negedge clk_i);
        bo_i = 5'd1;
        #1;
        chk(taken_o == 1'b1 && illegal_o == 1'b0, "R10 hold", {taken_o, illegal_o}, 2'b10);
        @(posedge clk_i); #1;
        chk(illegal_o == 1'b1, "R1 reserved code 1", illegal_o, 1);

        for (int c = 0; c < 32; c++) begin
            for (int form = 0; form < 2; form++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int ci = 0; ci < 5; ci++) begin
                        for (int cp = 0; cp < 2; cp++) begin
                            bit          legal, dec, illegal, crok, ctrok, is_zero, crbit, taken;
                            logic [63:0] nxt;
                            logic [1:0]  hint;
                            int          idx;
                            logic [31:0] pat;
                            @(negedge clk_i);
                            idx = (c * 7 + ci * 3 + m + form * 11) % 32;
                            pat = 32'hA5C3_0F96 ^ (32'h1111_1111 * ci);
                            if (cp == 1) pat = ~pat;
                            bo_i = c[4:0]; bi_i = idx[4:0]; cr_i = pat;
                            ctr_i = ctr_vals[ci]; mode32_i = m[0]; ctr_form_i = form[0];

                            legal   = legal_set(c);
                            dec     = legal && ((c / 4) % 2 == 0);
                            illegal = !legal || (form == 1 && dec);
                            if (illegal) dec = 1'b0;
                            nxt     = dec ? ctr_vals[ci] - 64'd1 : ctr_vals[ci];
                            is_zero = (m == 1) ? ((ctr_vals[ci] - 64'd1) % 64'h1_0000_0000 == 0)
                                               : (ctr_vals[ci] - 64'd1 == 0);
                            ctrok   = !dec || ((((c / 2) % 2) == 1) ? is_zero : !is_zero);
                            crbit   = (pat >> (31 - idx)) & 1;
                            crok    = (c >= 16) || (crbit == (((c / 8) % 2) == 1));
                            taken   = !illegal && ctrok && crok;
                            if (illegal) hint = 2'b00;
                            else if (c == 6 || c == 14 || c == 24 || c == 26) hint = 2'b10;
                            else if (c == 7 || c == 15 || c == 25 || c == 27) hint = 2'b11;
                            else hint = 2'b00;

                            @(posedge clk_i); #1;
                            if (form == 1 && legal && dec == 0 && ((c / 4) % 2 == 0))
                                chk(illegal_o == 1'b1, "R8 ctr form decrement", illegal_o, 1);
                            else
                                chk(illegal_o == illegal, "R1 legality", illegal_o, illegal);
                            chk(ctr_we_o == dec, "R2 write enable", ctr_we_o, dec);
                            chk(ctr_next_o == nxt, "R2 next count", ctr_next_o, nxt);
                            if (c == 20)
                                chk(taken_o == !illegal, "R6 always taken", taken_o, !illegal);
                            else if (dec && c >= 16)
                                chk(taken_o == taken, (m == 1) ? "R4 narrow counter test" : "R3 counter test", taken_o, taken);
                            else if (!illegal && c < 16)
                                chk(taken_o == taken, "R5 condition bit", taken_o, taken);
                            else
                                chk(taken_o == taken, "R9 illegal not taken", taken_o, taken);
                            chk(hint_o == hint, "R7 hint", hint_o, hint);
                        end
                    end
                end
            end
        end

        // R10: reset again clears outputs
        @(negedge clk_i);
        bo_i = 5'd18; ctr_i = 64'd1; ctr_form_i = 1'b0;
        rst_i = 1'b1;
        @(posedge clk_i); #1;
        chk(!ctr_we_o && !taken_o && ctr_next_o == 0, "R10 reset mid-run", {ctr_we_o, taken_o}, 0);
        done = 1'b1;
        finish_run();
    end
endmodule